// File: doc/BRIEF.md
# Flash Status Register Protection Unit

This block keeps the write-control status byte of a serial NOR flash and rules on every write-type request before the request reaches the array sequencer. A command decoder upstream hands it a command type, a 24-bit target address, the data byte of a status write and a strobe marking a frame that ended on a byte boundary. The unit answers each write-type request with a one-cycle grant or reject pulse and keeps the status byte up to date.

Three protection layers are checked. The write-enable latch must be set and no operation may be in progress. A block-protect field guards a region at the top of memory that doubles in size toward lower addresses with each step. A status-write lock applies while the lock bit is set and the write-protect pin is low. The sequencer reports the end of a granted operation on a done strobe, which clears the busy bit. The sector size, 64 KB or 256 KB, comes from a configuration input and sets the smallest protected region.

Top module: `flash_guard`

## Requirements
- R1: Synchronous active-high reset clears the status byte to 00h and holds grant and reject low. Status layout: bit 0 busy, bit 1 write-enable latch, bits 5:2 protect field (BP), bit 6 always 0, bit 7 status lock.
- R2: With the frame strobe high, op 1 sets the write-enable latch and op 2 clears it, with no grant or reject pulse. Without the strobe no op changes anything.
- R3: A write-type op (3 status write, 4 page program, 5 sector erase, 6 bulk erase) arriving while the latch is 0 or busy is 1 is rejected and leaves the status byte unchanged. Ops 0 and 7 do nothing.
- R4: A granted write gives a grant pulse in the cycle after the strobe, clears the latch and sets busy in the same cycle. A done pulse clears busy.
- R5: A granted status write loads BP from data bits 5:2 and the lock bit from data bit 7; data bits 0, 1 and 6 are ignored.
- R6: While the lock bit is 1 and the write-protect pin is low, a status write is rejected and BP, lock and latch keep their values; with the pin high it is granted.
- R7: With 64 KB sectors, BP=0 protects nothing and BP=n protects the top 2^(16+n) bytes; BP of 8 or more protects all addresses.
- R8: With 256 KB sectors, BP=n protects the top 2^(18+n) bytes; BP of 6 or more protects all addresses.
- R9: A page program or sector erase whose address lies in the protected region is rejected; one just below the region is granted.
- R10: A bulk erase is granted only when BP is 0.
- R11: Grant and reject are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Byte-aligned frame-complete strobe |
| req_op | input | 3 | Command type code |
| req_addr | input | 24 | Target byte address |
| req_data | input | 8 | Data byte of a status write |
| wp_n | input | 1 | Write-protect pin level, low asserts |
| cfg_large_sect | input | 1 | 1 selects 256 KB sectors, 0 selects 64 KB |
| op_done | input | 1 | End of the granted operation, clears busy |
| grant | output | 1 | Request accepted pulse |
| reject | output | 1 | Request refused pulse |
| status | output | 8 | Current status byte |

## Verification
The bench probes the edges of the protected region: the first protected address and the byte just below it, for both sector sizes, and the protect values at which the whole array becomes protected; a design off by one in the shift would grant a write inside the region or refuse one outside it. It sends requests while busy or with the latch clear, where a faulty unit would start a second operation or drop the latch. It exercises the status lock with the pin low and then high, catching a design that ignores the pin or the lock bit, and a bulk erase with a nonzero protect field.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_WREN   = 3'd1,
    OP_WRDI   = 3'd2,
    OP_WRSR   = 3'd3,
    OP_PROG   = 3'd4,
    OP_SERASE = 3'd5,
    OP_BERASE = 3'd6,
    OP_RSVD   = 3'd7
  } fg_op_e;

  localparam int SR_BUSY = 0;
  localparam int SR_WEL  = 1;
  localparam int SR_BP0  = 2;
  localparam int SR_LOCK = 7;
endpackage

// File: rtl/fg_region_check.sv
module fg_region_check #(
  parameter int ADDR_W   = 24,
  parameter int BP_W     = 4,
  parameter int SMALL_LG = 16,
  parameter int LARGE_LG = 18
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BP_W-1:0]   bp,
  input  logic              large_sect,
  output logic              in_region
);
  logic [ADDR_W-1:0] must_be_one;
  logic [7:0]        base_lg;
  logic [7:0]        floor_bit;

  assign base_lg   = large_sect ? 8'(LARGE_LG) : 8'(SMALL_LG);
  assign floor_bit = base_lg + 8'(bp);

  // Bits at or above the region floor must all be one for a hit.
  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign must_be_one[i] = (8'(i) >= floor_bit);
  end

  assign in_region = (bp != '0) && (&(addr | ~must_be_one));
endmodule

// File: rtl/fg_decide.sv
module fg_decide
  import flash_guard_pkg::*;
#(
  parameter int BP_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       valid,
  input  fg_op_e     op,
  input  logic       in_region,
  input  logic       wel,
  input  logic       busy,
  input  logic       lock,
  input  logic [BP_W-1:0] bp,
  input  logic       wp_n,
  output logic       grant_d,
  output logic       reject_d,
  output logic       wel_set,
  output logic       wel_clr,
  output logic       sr_load
);
  logic write_op;
  logic refuse;

  always_comb begin
    write_op = (op == OP_WRSR) || (op == OP_PROG) ||
               (op == OP_SERASE) || (op == OP_BERASE);
    refuse = !wel || busy;
    case (op)
      OP_WRSR:   refuse = refuse || (lock && !wp_n);
      OP_PROG,
      OP_SERASE: refuse = refuse || in_region;
      OP_BERASE: refuse = refuse || (bp != '0);
      default:   ;
    endcase
    grant_d  = valid && write_op && !refuse;
    reject_d = valid && write_op && refuse;
    wel_set  = valid && (op == OP_WREN);
    wel_clr  = valid && (op == OP_WRDI);
    sr_load  = grant_d && (op == OP_WRSR);
  end

  p_lock_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OP_WRSR && lock && !wp_n) |-> !grant_d);

  p_bulk_guard_r10: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OP_BERASE && bp != '0) |-> !grant_d);
endmodule

// File: rtl/fg_status_regs.sv
module fg_status_regs #(
  parameter int  BP_W       = 4,
  parameter logic [BP_W-1:0] RESET_BP = '0,
  parameter logic RESET_LOCK = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            grant_d,
  input  logic            reject_d,
  input  logic            wel_set,
  input  logic            wel_clr,
  input  logic            sr_load,
  input  logic [BP_W-1:0] new_bp,
  input  logic            new_lock,
  input  logic            done,
  output logic            busy_q,
  output logic            wel_q,
  output logic [BP_W-1:0] bp_q,
  output logic            lock_q,
  output logic            grant_q,
  output logic            reject_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      wel_q    <= 1'b0;
      bp_q     <= RESET_BP;
      lock_q   <= RESET_LOCK;
      grant_q  <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      grant_q  <= grant_d;
      reject_q <= reject_d;
      if (done)    busy_q <= 1'b0;
      if (wel_set) wel_q  <= 1'b1;
      if (wel_clr) wel_q  <= 1'b0;
      if (grant_d) begin
        busy_q <= 1'b1;
        wel_q  <= 1'b0;
      end
      if (sr_load) begin
        bp_q   <= new_bp;
        lock_q <= new_lock;
      end
    end
  end

  p_one_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    !(grant_q && reject_q));

  p_grant_state_r4: assert property (@(posedge clk) disable iff (rst)
    grant_q |-> (busy_q && !wel_q));

  p_grant_had_wel_r3: assert property (@(posedge clk) disable iff (rst)
    grant_q |-> $past(wel_q));

  p_reject_keeps_r3: assert property (@(posedge clk) disable iff (rst)
    reject_q |-> ($stable(bp_q) && $stable(lock_q) && $stable(wel_q)));
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int BP_W     = 4,
  parameter int SMALL_LG = 16,
  parameter int LARGE_LG = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              wp_n,
  input  logic              cfg_large_sect,
  input  logic              op_done,
  output logic              grant,
  output logic              reject,
  output logic [7:0]        status
);
  localparam int BP_HI = SR_BP0 + BP_W - 1;

  fg_op_e          op;
  logic            in_region;
  logic            busy_q, wel_q, lock_q;
  logic [BP_W-1:0] bp_q;
  logic            grant_d, reject_d, wel_set, wel_clr, sr_load;

  assign op = fg_op_e'(req_op);

  fg_region_check #(
    .ADDR_W(ADDR_W), .BP_W(BP_W), .SMALL_LG(SMALL_LG), .LARGE_LG(LARGE_LG)
  ) u_region (
    .addr(req_addr), .bp(bp_q), .large_sect(cfg_large_sect),
    .in_region(in_region)
  );

  fg_decide #(.BP_W(BP_W)) u_decide (
    .clk(clk), .rst(rst), .valid(req_valid), .op(op),
    .in_region(in_region), .wel(wel_q), .busy(busy_q), .lock(lock_q),
    .bp(bp_q), .wp_n(wp_n), .grant_d(grant_d), .reject_d(reject_d),
    .wel_set(wel_set), .wel_clr(wel_clr), .sr_load(sr_load)
  );

  fg_status_regs #(.BP_W(BP_W)) u_regs (
    .clk(clk), .rst(rst), .grant_d(grant_d), .reject_d(reject_d),
    .wel_set(wel_set), .wel_clr(wel_clr), .sr_load(sr_load),
    .new_bp(req_data[BP_HI:SR_BP0]), .new_lock(req_data[SR_LOCK]),
    .done(op_done), .busy_q(busy_q), .wel_q(wel_q), .bp_q(bp_q),
    .lock_q(lock_q), .grant_q(grant), .reject_q(reject)
  );

  always_comb begin
    status                  = '0;
    status[SR_BUSY]         = busy_q;
    status[SR_WEL]          = wel_q;
    status[BP_HI:SR_BP0]    = bp_q;
    status[SR_LOCK]         = lock_q;
  end
endmodule

// File: tb/flash_guard_bench.sv
`timescale 1ns/1ps
module flash_guard_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic        wp_n = 1'b1;
  logic        cfg_large_sect = 1'b0;
  logic        op_done = 1'b0;
  logic        grant, reject;
  logic [7:0]  status;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flash_guard u_flash_guard (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .wp_n(wp_n),
    .cfg_large_sect(cfg_large_sect), .op_done(op_done),
    .grant(grant), .reject(reject), .status(status)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present one frame; results are sampled at the following falling edge.
  task automatic send(logic [2:0] op, logic [23:0] addr, logic [7:0] data);
    @(negedge clk);
    req_op = op; req_addr = addr; req_data = data; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_op();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  task automatic load_sr(logic [7:0] data);
    send(3'd1, '0, '0);
    send(3'd3, '0, data);
    finish_op();
  endtask

  // Write request: expect grant or reject, then check the pulse ends.
  task automatic expect_write(string req, logic [2:0] op, logic [23:0] addr, bit ok);
    send(3'd1, '0, '0);
    send(op, addr, '0);
    chk({req, " grant"}, int'(grant), int'(ok));
    chk({req, " reject"}, int'(reject), int'(!ok));
    @(negedge clk);
    chk("R11 pulse ends", int'(grant | reject), 0);
    if (ok) finish_op();
    else send(3'd2, '0, '0);
  endtask

  task automatic t_reset();
    chk("R1 status", int'(status), 'h00);
    chk("R1 pulses", int'(grant | reject), 0);
  endtask

  task automatic t_latch();
    send(3'd1, '0, '0);
    chk("R2 set latch", int'(status), 'h02);
    chk("R2 no pulse", int'(grant | reject), 0);
    send(3'd2, '0, '0);
    chk("R2 clear latch", int'(status), 'h00);
    @(negedge clk); req_op = 3'd1; req_valid = 1'b0;
    @(negedge clk);
    chk("R2 no strobe", int'(status), 'h00);
  endtask

  task automatic t_no_latch();
    send(3'd4, 24'h001000, '0);
    chk("R3 no latch reject", int'(reject), 1);
    chk("R3 no latch status", int'(status), 'h00);
    send(3'd0, '0, '0);
    chk("R3 op0 no pulse", int'(grant | reject), 0);
  endtask

  task automatic t_status_write();
    send(3'd1, '0, '0);
    send(3'd3, '0, 8'h47);
    chk("R4 grant", int'(grant), 1);
    chk("R5 loaded, R4 busy", int'(status), 'h05);
    send(3'd1, '0, '0);
    chk("R2 latch while busy", int'(status), 'h07);
    send(3'd4, 24'h000000, '0);
    chk("R3 busy reject", int'(reject), 1);
    chk("R3 busy status", int'(status), 'h07);
    finish_op();
    chk("R4 done clears busy", int'(status), 'h06);
    send(3'd2, '0, '0);
  endtask

  task automatic t_small_region();
    cfg_large_sect = 1'b0;
    expect_write("R9 R7 bp1 top", 3'd4, 24'hFE0000, 0);
    expect_write("R9 R7 bp1 below", 3'd4, 24'hFDFFFF, 1);
    expect_write("R9 erase in region", 3'd5, 24'hFFFFFF, 0);
    expect_write("R10 bulk bp1", 3'd6, '0, 0);
    load_sr(8'h1C);
    expect_write("R7 bp7 floor", 3'd4, 24'h800000, 0);
    expect_write("R7 bp7 below", 3'd4, 24'h7FFFFF, 1);
    load_sr(8'h20);
    expect_write("R7 bp8 all", 3'd4, 24'h000000, 0);
    load_sr(8'h00);
    expect_write("R7 bp0 none", 3'd4, 24'hFFFFFF, 1);
  endtask

  task automatic t_large_region();
    cfg_large_sect = 1'b1;
    load_sr(8'h04);
    expect_write("R8 bp1 floor", 3'd4, 24'hF80000, 0);
    expect_write("R8 bp1 below", 3'd5, 24'hF7FFFF, 1);
    load_sr(8'h18);
    expect_write("R8 bp6 all", 3'd4, 24'h000000, 0);
    load_sr(8'h00);
    cfg_large_sect = 1'b0;
  endtask

  task automatic t_lock();
    load_sr(8'h80);
    chk("R6 lock set", int'(status), 'h80);
    wp_n = 1'b0;
    send(3'd1, '0, '0);
    send(3'd3, '0, 8'h04);
    chk("R6 locked reject", int'(reject), 1);
    chk("R6 locked status", int'(status), 'h82);
    wp_n = 1'b1;
    send(3'd3, '0, 8'h00);
    chk("R6 pin high grant", int'(grant), 1);
    chk("R6 pin high status", int'(status), 'h01);
    finish_op();
  endtask

  task automatic t_bulk();
    expect_write("R10 bulk bp0", 3'd6, '0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latch();
    t_no_latch();
    t_status_write();
    t_small_region();
    t_large_region();
    t_lock();
    t_bulk();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule